// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor core from normal execution into an exception handler. The core raises a request with a vector number and a choice between a short frame and a long access-fault frame. The block then saves the status word and forces supervisor mode with tracing off. If the core was in user mode, it parks the user stack pointer and switches to the supervisor stack pointer. It then writes the stack frame over a word-wide memory port and loads the new program counter from the vector table.

The same sequencer runs the power-on sequence after reset. It writes the fixed reset status word, clears any stopped state, and loads the stack pointer and the program counter from the two longwords at the bottom of memory. If the vector fetch of an entry faults, the block abandons the entry and runs this reset sequence instead.

The register file stays outside the block. The block reads the status word, the active stack pointer and the supervisor stack slot, and writes through single-cycle write strobes.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset is released, `req_ready` stays low while the block runs its reset sequence. The sequence writes status 0x2700 with `stop_clear` high in the same cycle. It then reads the words at 0, 2, 4 and 6. The active stack pointer becomes {word0, word2} with bit 0 cleared, the program counter becomes {word4, word6}, and `done` pulses.
- R2: On an entry the block writes a new status word and pulses `trace_cancel` in the same cycle. The new status word is the old one with bit 13 (supervisor) set and bit 15 (trace) cleared. All other bits keep their old values.
- R3: When the old bit 13 is 0, the active stack pointer is written to the user slot and the frame is built below `ssp_rd`. When the old bit 13 is 1, there is no user-slot write and the frame is built below `sp_rd`.
- R4: A short frame writes three words at ascending addresses: the old status word at base-6, then bits 31:16 of `req_pc` at base-4, then bits 15:0 at base-2. The active stack pointer becomes base-6.
- R5: A long frame writes seven words at ascending addresses from base-14. In order they are: `req_code`, the fault address (high word, then low word), `req_opcode`, the old status word, and the instruction address (high word, then low word). The active stack pointer becomes base-14.
- R6: After the frame, the block reads the word at vector×4 (high half) and the word at vector×4+2 (low half). It loads their concatenation into the program counter.
- R7: `done` is high for exactly one cycle, in the cycle after the program-counter write. The stack-pointer write happens in the same cycle as the program-counter write.
- R8: `req_ready` is high only when the block is idle. A request presented while it is low is ignored.
- R9: A memory request holds its address, direction and write data unchanged until `mem_ack`.
- R10: If `mem_fault` is returned with the acknowledge of a vector-table read, the entry is abandoned and the R1 reset sequence runs in full, ending with one `done` pulse.
- R11: A fault returned on a frame write is ignored. The rest of the frame, the vector fetch and the register updates proceed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the reset sequence starts on release |
| req_valid | input | 1 | Exception request |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vector | input | VEC_W | Vector number |
| req_long | input | 1 | 1 selects the long access-fault frame |
| req_code | input | 16 | Access code word for the long frame |
| req_fault_addr | input | 32 | Faulting address for the long frame |
| req_opcode | input | 16 | Opcode of the faulting instruction |
| req_inst_addr | input | 32 | Instruction start address for the long frame |
| req_pc | input | 32 | Return address for the short frame |
| done | output | 1 | One-cycle completion pulse |
| trace_cancel | output | 1 | Cancels any pending trace of the current instruction |
| stop_clear | output | 1 | Clears the core's stopped state |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, always even |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory cycle completes |
| mem_fault | input | 1 | Access fault, valid with mem_ack |
| sr_rd | input | 16 | Current status word |
| sr_we | output | 1 | Status word write strobe |
| sr_wdata | output | 16 | Status word write data |
| sp_rd | input | 32 | Active stack pointer |
| ssp_rd | input | 32 | Supervisor stack slot |
| sp_we | output | 1 | Active stack pointer write strobe |
| sp_wdata | output | 32 | Active stack pointer write data |
| usp_we | output | 1 | User stack slot write strobe |
| usp_wdata | output | 32 | User stack slot write data |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 32 | Program counter write data |

## Verification
Entries are made from user mode and from supervisor mode. This shows whether the frame base comes from the right stack and whether the user slot is saved only when the mode changes. Short and long frames are compared word by word against a queue of expected bus cycles, which catches a swapped field or an off-by-two address. Wait states are inserted on the memory port, and requests are driven while the block is busy, to test hold-off and signal stability. Faults are injected on a frame write and on a vector read, which separates the ignored case from the one that falls back to reset.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RSR,
    ST_RLD,
    ST_CAPT,
    ST_PUSH,
    ST_VEC,
    ST_FIN,
    ST_DONE
  } seq_state_t;

  localparam int SR_SUPER_BIT  = 13;
  localparam int SR_TRACE_BIT  = 15;
  localparam logic [15:0] SR_RESET_VAL = 16'h2700;
  localparam int SHORT_WORDS   = 3;
  localparam int LONG_WORDS    = 7;

  function automatic logic [2:0] frame_words(input logic long_f);
    return long_f ? 3'(LONG_WORDS) : 3'(SHORT_WORDS);
  endfunction

  function automatic logic [31:0] frame_bytes(input logic long_f);
    return {28'd0, frame_words(long_f), 1'b0};
  endfunction

  function automatic logic [15:0] entry_sr(input logic [15:0] old_sr);
    logic [15:0] r;
    r = old_sr;
    r[SR_SUPER_BIT] = 1'b1;
    r[SR_TRACE_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] even_addr(input logic [31:0] a);
    return {a[31:1], 1'b0};
  endfunction

  function automatic logic [31:0] word_offset(input logic [2:0] k);
    return {28'd0, k, 1'b0};
  endfunction

endpackage

// File: rtl/exc_stack_bank.sv
module exc_stack_bank
  import exc_seq_pkg::*;
(
  input  logic [15:0] old_sr,
  input  logic [31:0] sp_rd,
  input  logic [31:0] ssp_rd,
  input  logic        long_frame,
  output logic        swap,
  output logic [31:0] frame_base
);
  logic [31:0] top_sp;

  always_comb begin
    swap       = ~old_sr[SR_SUPER_BIT];
    top_sp     = swap ? ssp_rd : sp_rd;
    frame_base = top_sp - frame_bytes(long_frame);
  end
endmodule

// File: rtl/exc_frame_builder.sv
module exc_frame_builder
  import exc_seq_pkg::*;
(
  input  logic        long_frame,
  input  logic [2:0]  word_idx,
  input  logic [31:0] frame_base,
  input  logic [15:0] saved_sr,
  input  logic [15:0] code,
  input  logic [15:0] opcode,
  input  logic [31:0] fault_addr,
  input  logic [31:0] inst_addr,
  input  logic [31:0] ret_pc,
  output logic [31:0] word_addr,
  output logic [15:0] word_data,
  output logic        last_word
);
  always_comb begin
    word_addr = frame_base + word_offset(word_idx);
    last_word = (word_idx == frame_words(long_frame) - 3'd1);
    word_data = 16'h0000;
    if (long_frame) begin
      case (word_idx)
        3'd0:    word_data = code;
        3'd1:    word_data = fault_addr[31:16];
        3'd2:    word_data = fault_addr[15:0];
        3'd3:    word_data = opcode;
        3'd4:    word_data = saved_sr;
        3'd5:    word_data = inst_addr[31:16];
        3'd6:    word_data = inst_addr[15:0];
        default: word_data = 16'h0000;
      endcase
    end else begin
      case (word_idx)
        3'd0:    word_data = saved_sr;
        3'd1:    word_data = ret_pc[31:16];
        3'd2:    word_data = ret_pc[15:0];
        default: word_data = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_long,
  input  logic [15:0]      req_code,
  input  logic [31:0]      req_fault_addr,
  input  logic [15:0]      req_opcode,
  input  logic [31:0]      req_inst_addr,
  input  logic [31:0]      req_pc,
  output logic             done,
  output logic             trace_cancel,
  output logic             stop_clear,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_fault,
  input  logic [15:0]      sr_rd,
  output logic             sr_we,
  output logic [15:0]      sr_wdata,
  input  logic [31:0]      sp_rd,
  input  logic [31:0]      ssp_rd,
  output logic             sp_we,
  output logic [31:0]      sp_wdata,
  output logic             usp_we,
  output logic [31:0]      usp_wdata,
  output logic             pc_we,
  output logic [31:0]      pc_wdata
);
  localparam int VA_PAD = 32 - VEC_W - 2;

  seq_state_t       state;
  logic [2:0]       idx;
  logic [15:0]      hi_q;
  logic [31:0]      sp_q;
  logic [31:0]      pc_q;
  logic [15:0]      old_sr_q;
  logic [VEC_W-1:0] vec_q;
  logic             long_q;
  logic [15:0]      code_q;
  logic [15:0]      opc_q;
  logic [31:0]      faddr_q;
  logic [31:0]      iaddr_q;
  logic [31:0]      rpc_q;

  logic        swap;
  logic [31:0] frame_base;
  logic [31:0] push_addr;
  logic [15:0] push_data;
  logic        push_last;
  logic [31:0] vec_addr;

  // Named events for the checker
  logic ev_accept;
  logic ev_bus_fire;
  logic ev_vec_fault;

  exc_stack_bank u_bank (
    .old_sr     (sr_rd),
    .sp_rd      (sp_rd),
    .ssp_rd     (ssp_rd),
    .long_frame (long_q),
    .swap       (swap),
    .frame_base (frame_base)
  );

  exc_frame_builder u_frame (
    .long_frame (long_q),
    .word_idx   (idx),
    .frame_base (sp_q),
    .saved_sr   (old_sr_q),
    .code       (code_q),
    .opcode     (opc_q),
    .fault_addr (faddr_q),
    .inst_addr  (iaddr_q),
    .ret_pc     (rpc_q),
    .word_addr  (push_addr),
    .word_data  (push_data),
    .last_word  (push_last)
  );

  assign vec_addr     = {{VA_PAD{1'b0}}, vec_q, 2'b00} | {30'd0, idx[0], 1'b0};
  assign ev_accept    = (state == ST_IDLE) && req_valid;
  assign ev_bus_fire  = mem_req && mem_ack;
  assign ev_vec_fault = (state == ST_VEC) && mem_ack && mem_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RSR;
      idx      <= '0;
      hi_q     <= '0;
      sp_q     <= '0;
      pc_q     <= '0;
      old_sr_q <= '0;
      vec_q    <= '0;
      long_q   <= 1'b0;
      code_q   <= '0;
      opc_q    <= '0;
      faddr_q  <= '0;
      iaddr_q  <= '0;
      rpc_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vec_q   <= req_vector;
            long_q  <= req_long;
            code_q  <= req_code;
            opc_q   <= req_opcode;
            faddr_q <= req_fault_addr;
            iaddr_q <= req_inst_addr;
            rpc_q   <= req_pc;
            state   <= ST_CAPT;
          end
        end
        ST_CAPT: begin
          old_sr_q <= sr_rd;
          sp_q     <= frame_base;
          idx      <= '0;
          state    <= ST_PUSH;
        end
        ST_PUSH: begin
          if (mem_ack) begin
            if (push_last) begin
              idx   <= '0;
              state <= ST_VEC;
            end else begin
              idx <= idx + 3'd1;
            end
          end
        end
        ST_VEC: begin
          if (mem_ack) begin
            if (mem_fault) begin
              idx   <= '0;
              state <= ST_RSR;
            end else if (idx == 3'd0) begin
              hi_q <= mem_rdata;
              idx  <= 3'd1;
            end else begin
              pc_q  <= {hi_q, mem_rdata};
              state <= ST_FIN;
            end
          end
        end
        ST_RSR: begin
          idx   <= '0;
          state <= ST_RLD;
        end
        ST_RLD: begin
          if (mem_ack) begin
            idx <= idx + 3'd1;
            case (idx[1:0])
              2'd0: hi_q <= mem_rdata;
              2'd1: sp_q <= even_addr({hi_q, mem_rdata});
              2'd2: hi_q <= mem_rdata;
              default: begin
                pc_q  <= {hi_q, mem_rdata};
                state <= ST_FIN;
              end
            endcase
          end
        end
        ST_FIN:  state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_PUSH: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = push_data;
      end
      ST_VEC: begin
        mem_req  = 1'b1;
        mem_addr = vec_addr;
      end
      ST_RLD: begin
        mem_req  = 1'b1;
        mem_addr = word_offset({1'b0, idx[1:0]});
      end
      default: ;
    endcase
  end

  assign req_ready    = (state == ST_IDLE);
  assign trace_cancel = (state == ST_CAPT);
  assign stop_clear   = (state == ST_RSR);
  assign sr_we        = (state == ST_CAPT) || (state == ST_RSR);
  assign sr_wdata     = (state == ST_RSR) ? SR_RESET_VAL : entry_sr(sr_rd);
  assign usp_we       = (state == ST_CAPT) && swap;
  assign usp_wdata    = sp_rd;
  assign pc_we        = (state == ST_FIN);
  assign pc_wdata     = pc_q;
  assign sp_we        = (state == ST_FIN);
  assign sp_wdata     = sp_q;
  assign done         = (state == ST_DONE);

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic        trace_cancel,
  input logic        stop_clear,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ack,
  input logic [15:0] sr_rd,
  input logic        sr_we,
  input logic [15:0] sr_wdata,
  input logic [31:0] sp_rd,
  input logic        sp_we,
  input logic        usp_we,
  input logic [31:0] usp_wdata,
  input logic        pc_we,
  input logic        ev_vec_fault,
  input logic        ev_bus_fire
);
  AST_RESET_SR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clear |-> sr_we && sr_wdata == 16'h2700); // R1

  AST_ENTRY_SR: assert property (@(posedge clk) disable iff (!rst_n)
    trace_cancel |-> sr_we && sr_wdata[13] && !sr_wdata[15]
                     && sr_wdata[14] == sr_rd[14] && sr_wdata[12:0] == sr_rd[12:0]); // R2

  AST_USP_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    usp_we |-> !sr_rd[13] && usp_wdata == sp_rd && trace_cancel); // R3

  AST_DONE_AFTER_PC: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> done); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_SP_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> sp_we); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || pc_we || mem_req || sr_we) |-> !req_ready); // R8

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata)); // R9

  AST_BUS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_fire |-> !mem_addr[0]); // R9

  AST_VEC_FAULT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec_fault |=> stop_clear); // R10
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .done         (done),
  .trace_cancel (trace_cancel),
  .stop_clear   (stop_clear),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .sr_rd        (sr_rd),
  .sr_we        (sr_we),
  .sr_wdata     (sr_wdata),
  .sp_rd        (sp_rd),
  .sp_we        (sp_we),
  .usp_we       (usp_we),
  .usp_wdata    (usp_wdata),
  .pc_we        (pc_we),
  .ev_vec_fault (ev_vec_fault),
  .ev_bus_fire  (ev_bus_fire)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vector = '0;
  logic        req_long = 1'b0;
  logic [15:0] req_code = '0;
  logic [31:0] req_fault_addr = '0;
  logic [15:0] req_opcode = '0;
  logic [31:0] req_inst_addr = '0;
  logic [31:0] req_pc = '0;
  logic        done, trace_cancel, stop_clear;
  logic        mem_req, mem_we, mem_ack, mem_fault;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] sr_reg, sr_wdata;
  logic        sr_we, sp_we, usp_we, pc_we;
  logic [31:0] sp_act, ssp_reg, usp_reg, pc_reg;
  logic [31:0] sp_wdata, usp_wdata, pc_wdata;

  always #5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector), .req_long(req_long), .req_code(req_code),
    .req_fault_addr(req_fault_addr), .req_opcode(req_opcode),
    .req_inst_addr(req_inst_addr), .req_pc(req_pc), .done(done),
    .trace_cancel(trace_cancel), .stop_clear(stop_clear), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_fault(mem_fault),
    .sr_rd(sr_reg), .sr_we(sr_we), .sr_wdata(sr_wdata), .sp_rd(sp_act),
    .ssp_rd(ssp_reg), .sp_we(sp_we), .sp_wdata(sp_wdata), .usp_we(usp_we),
    .usp_wdata(usp_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata)
  );

  // Memory and register-file models
  logic [15:0] mem [0:1023];
  int          wait_n = 0;
  int          wcnt = 0;
  logic        fault_en = 1'b0;
  logic [31:0] fault_addr = '0;

  assign mem_ack   = mem_req && (wcnt == wait_n);
  assign mem_fault = mem_ack && fault_en && (mem_addr == fault_addr);
  assign mem_rdata = mem[mem_addr[10:1]];

  always @(posedge clk) begin
    if (!mem_req || mem_ack) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (mem_req && mem_ack && mem_we && !mem_fault) mem[mem_addr[10:1]] <= mem_wdata;
    if (sr_we)  sr_reg  <= sr_wdata;
    if (sp_we)  sp_act  <= sp_wdata;
    if (usp_we) usp_reg <= usp_wdata;
    if (pc_we)  pc_reg  <= pc_wdata;
  end

  // Scoreboard
  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [15:0] data;
    string       tag;
  } bus_item_t;

  bus_item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic        tc_seen, sc_seen, usp_seen, prev_pc_we, prev_wait;
  logic [15:0] last_sr;
  logic [31:0] last_usp, prev_addr;
  bus_item_t   it;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input bit we, input logic [31:0] a, input logic [15:0] d,
                          input string tag);
    bus_item_t x;
    x.we = we; x.addr = a; x.data = d; x.tag = tag;
    exp_q.push_back(x);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wait) begin
        chk("R9 hold", {mem_req, mem_addr[30:0]}, {1'b1, prev_addr[30:0]});
      end
      if (mem_req && mem_ack) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected bus cycle", mem_addr, 32'hFFFF_FFFF);
        end else begin
          it = exp_q.pop_front();
          chk(it.tag, {mem_we, mem_addr[30:0]}, {it.we, it.addr[30:0]});
          if (it.we) chk(it.tag, {16'd0, mem_wdata}, {16'd0, it.data});
        end
      end
      if (sr_we) last_sr = sr_wdata;
      if (trace_cancel) tc_seen = 1'b1;
      if (stop_clear) sc_seen = 1'b1;
      if (usp_we) begin usp_seen = 1'b1; last_usp = usp_wdata; end
      if (done) chk("R7 pc write precedes done", {31'd0, prev_pc_we}, 32'd1);
      prev_pc_we = pc_we;
      prev_wait  = mem_req && !mem_ack;
      prev_addr  = mem_addr;
    end else begin
      prev_pc_we = 1'b0;
      prev_wait  = 1'b0;
    end
  end

  task automatic clear_flags();
    tc_seen = 0; sc_seen = 0; usp_seen = 0;
  endtask

  task automatic expect_reset_reads(input string tag);
    for (int k = 0; k < 4; k++) push_exp(1'b0, 32'(2 * k), 16'h0, tag);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " sr"}, {16'd0, sr_reg}, 32'h0000_2700);
    chk({tag, " sp"}, sp_act, {mem[0], mem[1]} & 32'hFFFF_FFFE);
    chk({tag, " pc"}, pc_reg, {mem[2], mem[3]});
    chk({tag, " stop_clear"}, {31'd0, sc_seen}, 32'd1);
    chk({tag, " queue drained"}, exp_q.size(), 0);
  endtask

  // Driver: computes the expected frame and bus order, then issues the request
  task automatic do_entry(input logic [7:0] vec, input bit lng, input logic [15:0] code,
                          input logic [31:0] fa, input logic [15:0] opc,
                          input logic [31:0] ia, input logic [31:0] rpc,
                          input bit poke_busy, input bit dbl_fault);
    logic [15:0] old_sr, new_sr;
    logic [31:0] base, old_sp, exp_pc;
    logic [15:0] w [7];
    int n;
    bit user;
    old_sr = sr_reg;
    old_sp = sp_act;
    user   = (old_sr[13] == 1'b0);
    n      = lng ? 7 : 3;
    base   = (user ? ssp_reg : sp_act) - 32'(2 * n);
    new_sr = {1'b0, old_sr[14], 1'b1, old_sr[12:0]};
    exp_pc = {mem[int'(vec) * 2], mem[int'(vec) * 2 + 1]};
    if (lng) begin
      w[0] = code; w[1] = fa[31:16]; w[2] = fa[15:0]; w[3] = opc;
      w[4] = old_sr; w[5] = ia[31:16]; w[6] = ia[15:0];
    end else begin
      w[0] = old_sr; w[1] = rpc[31:16]; w[2] = rpc[15:0];
      w[3] = 0; w[4] = 0; w[5] = 0; w[6] = 0;
    end
    for (int k = 0; k < n; k++)
      push_exp(1'b1, base + 32'(2 * k), w[k], lng ? "R5 frame word" : "R4 frame word");
    push_exp(1'b0, {22'd0, vec, 2'b00}, 16'h0, "R6 vector high read");
    if (dbl_fault) expect_reset_reads("R10 reset reads");
    else push_exp(1'b0, {22'd0, vec, 2'b10}, 16'h0, "R6 vector low read");
    clear_flags();

    while (!req_ready) @(negedge clk);
    req_vector = vec; req_long = lng; req_code = code; req_fault_addr = fa;
    req_opcode = opc; req_inst_addr = ia; req_pc = rpc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      req_vector = 8'd99; req_long = 1'b1; req_valid = 1'b1;
      for (int c = 0; c < 3; c++) begin
        chk("R8 ready low while busy", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    wait_done();

    if (dbl_fault) begin
      check_reset_state("R10");
    end else begin
      chk("R2 entry status", {16'd0, last_sr}, {16'd0, new_sr});
      chk("R2 trace cancel", {31'd0, tc_seen}, 32'd1);
      chk("R3 user slot saved", {31'd0, usp_seen}, {31'd0, user});
      if (user) chk("R3 user slot value", last_usp, old_sp);
      chk(lng ? "R5 stack pointer" : "R4 stack pointer", sp_act, base);
      chk("R6 program counter", pc_reg, exp_pc);
      chk("R4 queue drained", exp_q.size(), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 7 + 3);
    mem[0] = 16'h0000; mem[1] = 16'h0701;       // reset stack pointer (odd on purpose)
    mem[2] = 16'h0000; mem[3] = 16'h0246;       // reset program counter
    sr_reg = 16'h0000; sp_act = 32'h0; ssp_reg = 32'h600; usp_reg = 32'h0; pc_reg = 32'h0;
    clear_flags();
    expect_reset_reads("R1 reset reads");
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", {31'd0, req_ready}, 32'd0);
    chk("R7 done low in reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready low during reset sequence", {31'd0, req_ready}, 32'd0);
    wait_done();
    check_reset_state("R1");

    // Short frame from user mode with trace set, zero wait states
    sr_reg = 16'h8005; sp_act = 32'h300; ssp_reg = 32'h600;
    do_entry(8'd5, 1'b0, 16'h0, 32'h0, 16'h0, 32'h0, 32'h0012_3456, 1'b0, 1'b0);

    // Short frame from supervisor mode, wait states, requests while busy
    wait_n = 2;
    do_entry(8'd8, 1'b0, 16'h0, 32'h0, 16'h0, 32'h0, 32'hCAFE_0102, 1'b1, 1'b0);

    // Long frame from user mode
    wait_n = 1;
    sr_reg = 16'h0015; sp_act = 32'h200; ssp_reg = 32'h500;
    do_entry(8'd2, 1'b1, 16'h0015, 32'h1357_9BDF, 16'h4E71, 32'h0000_0ABC,
             32'h0, 1'b0, 1'b0);

    // Fault on a frame write is ignored (R11)
    wait_n = 0;
    fault_en = 1'b1; fault_addr = sp_act - 32'd4;
    do_entry(8'd9, 1'b0, 16'h0, 32'h0, 16'h0, 32'h0, 32'h0000_7777, 1'b0, 1'b0);
    chk("R11 sequence completed after write fault", {31'd0, req_ready}, 32'd1);
    fault_en = 1'b0;

    // Fault on the vector fetch of a long frame falls back to reset (R10)
    fault_en = 1'b1; fault_addr = 32'd12;
    do_entry(8'd3, 1'b1, 16'h0005, 32'h0000_1001, 16'h3010, 32'h0000_0400,
             32'h0, 1'b0, 1'b1);
    fault_en = 1'b0;
    chk("R8 ready after completion", {31'd0, req_ready}, 32'd1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule